// File: doc/BRIEF.md
# Watchdog Control With Timed Disable

This block holds the control register of a watchdog timer and the timeout counter that the register governs. Software writes an 8-bit control byte over a simple write strobe and reads the register back on a separate read bus. The byte contains an enable bit, a disarm-permit bit and a 3-bit timeout select. Software can set the enable bit at any time. It can clear the enable bit only through a two-step sequence, so a stray write cannot switch the watchdog off.

The disable sequence has two writes. The first write sets the disarm-permit and enable bits together, which opens a permit window four clock cycles long. The second write clears the enable bit, and it must arrive while the window is still open. Hardware drops the disarm-permit bit by itself when the window closes. While the watchdog is enabled, a counter advances on each base tick. When it reaches the selected limit, it raises a one-cycle reset request and starts a new period. A kick input restarts the period early. The parameter `BASE_EXP` sets the shortest period to 2^BASE_EXP base ticks.

Top module: `wdt_guard`

## Requirements
- R1: After reset, `rd_data` reads 0x00 and `rst_req` is low.
- R2: In `rd_data`, bits 7:5 always read zero, bit 4 is the disarm-permit bit, bit 3 is the enable bit and bits 2:0 are the timeout select. A write takes effect at the clock edge where `wr_en` is high, and the readback shows the new value one edge after that write.
- R3: A write with bit 3 set turns the watchdog on.
- R4: A write with bit 3 clear leaves the watchdog enabled when no permit window is open. A write of bit 4 alone, without bit 3, opens no window.
- R5: A write with bits 4 and 3 both set opens a permit window. Bit 4 then reads one after the arming edge and after each of the next three edges, and reads zero after the fourth edge, with no further write.
- R6: A write with bit 3 clear on the 1st through 4th edge after the arming write turns the watchdog off. The same write on the 5th edge has no effect.
- R7: While the watchdog is enabled, `rst_req` goes high for exactly one cycle after the 2^(BASE_EXP+N)-th base tick of a period, where N is the timeout select. A base tick is an edge with `tick` high. A new period then starts at once. Edges with `tick` low do not advance the count.
- R8: A `kick` edge restarts the period and suppresses the request at that edge.
- R9: While the watchdog is disabled, `rst_req` stays low and the count stays at zero, so a later enable starts a full period.
- R10: A new timeout select takes effect only at the next period restart: an expiry, a kick, or the disabled state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the control register |
| wr_data | input | 8 | Control byte written when `wr_en` is high |
| rd_data | output | 8 | Register readback |
| tick | input | 1 | Base tick enable for the timeout count |
| kick | input | 1 | Restarts the timeout period |
| rst_req | output | 1 | One-cycle reset request on timeout |

## Verification
Every result has a known latency. A write shows in `rd_data` one edge after its strobe. The disarm-permit bit falls after the fourth edge that follows the arming write. A disable write decides its outcome at the edge it is presented. `rst_req` rises after the 2^(BASE_EXP+N)-th ticked edge of the period. The bench drives and samples on falling edges. It places the disable write on an exact edge number after arming, and it counts falling edges from the enabling or restarting edge until the request appears, comparing that count with the computed period length.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int REG_W   = 8;
  localparam int SEL_W   = 3;
  localparam int N_SEL   = 1 << SEL_W;
  localparam int BIT_TOE = 4;
  localparam int BIT_EN  = 3;
endpackage

// File: rtl/wdt_ctrl_reg.sv
module wdt_ctrl_reg
  import wdt_pkg::*;
#(
  parameter int WIN_CYCLES = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic             enable,
  output logic [SEL_W-1:0] sel,
  output logic [REG_W-1:0] rd_data
);
  localparam int WIN_W = $clog2(WIN_CYCLES + 1);
  localparam logic [WIN_W-1:0] WIN_LOAD = WIN_W'(WIN_CYCLES);

  logic [WIN_W-1:0] win_q;
  logic             en_q;
  logic [SEL_W-1:0] sel_q;
  logic             permit;
  logic             arm;

  assign permit = (win_q != '0);
  assign arm    = wr_en && wr_data[BIT_TOE] && wr_data[BIT_EN];

  always_ff @(posedge clk) begin
    if (rst) begin
      win_q <= '0;
      en_q  <= 1'b0;
      sel_q <= '0;
    end else begin
      // permit window: reload on arming, otherwise run down to zero
      if (arm)
        win_q <= WIN_LOAD;
      else if (permit)
        win_q <= win_q - 1'b1;
      if (wr_en) begin
        sel_q <= wr_data[SEL_W-1:0];
        if (wr_data[BIT_EN])
          en_q <= 1'b1;
        else if (permit)
          en_q <= 1'b0;
      end
    end
  end

  assign enable  = en_q;
  assign sel     = sel_q;
  assign rd_data = {{(REG_W-5){1'b0}}, permit, en_q, sel_q};
endmodule

// File: rtl/wdt_limit_sel.sv
module wdt_limit_sel
  import wdt_pkg::*;
#(
  parameter int BASE_EXP = 14,
  parameter int CNT_W    = BASE_EXP + N_SEL - 1
) (
  input  logic [SEL_W-1:0] sel,
  output logic [CNT_W-1:0] last
);
  localparam logic [CNT_W:0] ONE = 1;

  logic [CNT_W-1:0] lim [N_SEL];

  for (genvar g = 0; g < N_SEL; g++) begin : g_lim
    assign lim[g] = CNT_W'((ONE << (BASE_EXP + g)) - 1'b1);
  end

  assign last = lim[sel];
endmodule

// File: rtl/wdt_timeout_cnt.sv
module wdt_timeout_cnt
  import wdt_pkg::*;
#(
  parameter int BASE_EXP = 14,
  parameter int CNT_W    = BASE_EXP + N_SEL - 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             tick,
  input  logic             kick,
  input  logic [SEL_W-1:0] sel_live,
  output logic             rst_req
);
  logic [CNT_W-1:0] cnt_q;
  logic [SEL_W-1:0] sel_act;
  logic [CNT_W-1:0] last;
  logic             req_q;

  wdt_limit_sel #(.BASE_EXP(BASE_EXP), .CNT_W(CNT_W)) u_lim (
    .sel  (sel_act),
    .last (last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      sel_act <= '0;
      req_q   <= 1'b0;
    end else begin
      req_q <= 1'b0;
      if (!enable || kick) begin
        cnt_q   <= '0;
        sel_act <= sel_live;
      end else if (tick) begin
        if (cnt_q == last) begin
          cnt_q   <= '0;
          sel_act <= sel_live;
          req_q   <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign rst_req = req_q;
endmodule

// File: rtl/wdt_guard.sv
module wdt_guard
  import wdt_pkg::*;
#(
  parameter int BASE_EXP   = 14,
  parameter int WIN_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic       tick,
  input  logic       kick,
  output logic       rst_req
);
  localparam int CNT_W = BASE_EXP + N_SEL - 1;

  logic             enable;
  logic [SEL_W-1:0] sel;

  wdt_ctrl_reg #(.WIN_CYCLES(WIN_CYCLES)) u_reg (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .enable  (enable),
    .sel     (sel),
    .rd_data (rd_data)
  );

  wdt_timeout_cnt #(.BASE_EXP(BASE_EXP), .CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .enable   (enable),
    .tick     (tick),
    .kick     (kick),
    .sel_live (sel),
    .rst_req  (rst_req)
  );
endmodule

// File: rtl/wdt_guard_chk.sv
module wdt_guard_chk (
  input logic       clk,
  input logic       rst,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic       kick,
  input logic [7:0] rd_data,
  input logic       rst_req
);
  p_rsv_zero_r2: assert property (@(posedge clk) disable iff (rst)
    rd_data[7:5] == 3'b000);

  p_en_set_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_data[3]) |=> rd_data[3]);

  p_en_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (rd_data[3] && !rd_data[4]) |=> rd_data[3]);

  p_arm_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_data[4] && wr_data[3]) |=> rd_data[4]);

  p_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    rst_req |=> !rst_req);

  p_kick_r8: assert property (@(posedge clk) disable iff (rst)
    kick |=> !rst_req);

  p_off_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    !rd_data[3] |=> !rst_req);
endmodule

bind wdt_guard wdt_guard_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .wr_en   (wr_en),
  .wr_data (wr_data),
  .kick    (kick),
  .rd_data (rd_data),
  .rst_req (rst_req)
);

// File: tb/wdt_guard_test.sv
`timescale 1ns/1ps
module wdt_guard_test;
  localparam int BEXP = 2;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       tick = 1'b1;
  logic       kick = 1'b0;
  logic [7:0] rd_data;
  logic       rst_req;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  wdt_guard #(.BASE_EXP(BEXP), .WIN_CYCLES(4)) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .tick(tick), .kick(kick), .rst_req(rst_req)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; wr_en = 1'b0; kick = 1'b0; tick = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wr(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = 8'h00;
  endtask

  // falling edges until rst_req is seen (0 if never within limit)
  task automatic wait_req(input int maxc, output int n);
    n = 0;
    for (int i = 1; i <= maxc; i++) begin
      @(negedge clk);
      if (rst_req) begin n = i; break; end
    end
  endtask

  function automatic int per(input int s);
    return 1 << (BEXP + s);
  endfunction

  task automatic t_reset();
    do_reset();
    chk("R1 readback", rd_data, 0);
    chk("R1 request", rst_req, 0);
  endtask

  task automatic t_layout();
    do_reset();
    wr(8'hFF);
    chk("R2 reserved zero", rd_data, 8'h1F);
    do_reset();
    wr(8'hE5);
    chk("R2 select readback", rd_data, 8'h05);
  endtask

  task automatic t_enable_hold();
    do_reset();
    wr(8'h08);
    chk("R3 enable set", rd_data[3], 1);
    wr(8'h00);
    chk("R4 plain clear ignored", rd_data[3], 1);
    wr(8'h10);
    wr(8'h00);
    chk("R4 permit-only write opens nothing", rd_data[3], 1);
  endtask

  task automatic t_permit_bit();
    do_reset();
    wr(8'h08);
    wr(8'h18);
    chk("R5 permit after arm", rd_data[4], 1);
    repeat (3) @(negedge clk);
    chk("R5 permit after 3rd edge", rd_data[4], 1);
    @(negedge clk);
    chk("R5 permit gone after 4th edge", rd_data[4], 0);
  endtask

  task automatic t_window(input int k, input int exp_en);
    do_reset();
    wr(8'h08);
    wr(8'h18);
    repeat (k - 1) @(negedge clk);
    wr(8'h00);
    chk($sformatf("R6 disable on edge %0d", k), rd_data[3], exp_en);
  endtask

  task automatic t_timeout(input int s);
    int n;
    do_reset();
    wr(8'(s));
    wr(8'h08 | 8'(s));
    wait_req(2000, n);
    chk($sformatf("R7 first expiry sel %0d", s), n, per(s));
    wait_req(2000, n);
    chk($sformatf("R7 one-cycle pulse and restart sel %0d", s), n, per(s));
  endtask

  task automatic t_tick_gate();
    int n;
    do_reset();
    tick = 1'b0;
    wr(8'h08);
    wait_req(30, n);
    chk("R7 no count without ticks", n, 0);
    tick = 1'b1;
    wait_req(100, n);
    chk("R7 count resumes with ticks", n, per(0));
  endtask

  task automatic t_kick();
    int n;
    do_reset();
    wr(8'h08);
    repeat (2) @(negedge clk);
    kick = 1'b1;
    @(negedge clk);
    kick = 1'b0;
    chk("R8 no request at kick", rst_req, 0);
    wait_req(100, n);
    chk("R8 full period after kick", n, per(0));
  endtask

  task automatic t_disabled();
    int n;
    do_reset();
    wr(8'h01);
    wait_req(40, n);
    chk("R9 quiet while disabled", n, 0);
    wr(8'h09);
    wait_req(100, n);
    chk("R9 full period after enable", n, per(1));
  endtask

  task automatic t_sel_change();
    int n;
    do_reset();
    wr(8'h08);
    wr(8'h09);
    wait_req(100, n);
    chk("R10 old select until restart", n, per(0) - 1);
    wait_req(100, n);
    chk("R10 new select after restart", n, per(1));
  endtask

  initial begin
    t_reset();
    t_layout();
    t_enable_hold();
    t_permit_bit();
    t_window(1, 0);
    t_window(4, 0);
    t_window(5, 1);
    t_timeout(0);
    t_timeout(3);
    t_tick_gate();
    t_kick();
    t_disabled();
    t_sel_change();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule